// File: doc/BRIEF.md
# SDRAM Command Gap Gate

This block stands between the command sequencer of an SDRAM controller and the memory's command pins. The sequencer presents one command at a time, with a bank number and, for writes, a flag that marks a single-beat write. The gate holds that command until every minimum spacing that applies to it has elapsed in the addressed bank. It then lets the command through for exactly one cycle and pulses an accept strobe so the sequencer can move on. In every other cycle the pins carry a no-operation code.

Three spacings are enforced: row activation to a read or write, precharge to the next activation, and a write to the precharge that follows it. Each spacing has a one-bit select that chooses between two fixed clock counts. A fourth enable adds a longer hold after single-beat writes. Software may clear it, and the ordinary write-to-precharge spacing then applies. Every bank keeps its own elapsed-cycle counters, so traffic in one bank never delays another.

Top module: `sdram_cmd_gate`

## Requirements
- R1: A read (code 2) or write (code 3) to a bank is accepted only when at least 2 cycles (`cfg_trcd_sel`=0) or 3 cycles (`cfg_trcd_sel`=1) have passed since that bank's last accepted activate (code 1). The distance is counted as the difference of the accept cycle numbers.
- R2: An activate to a bank is accepted only when at least 2 cycles (`cfg_trp_sel`=0) or 3 cycles (`cfg_trp_sel`=1) have passed since that bank's last accepted precharge (code 4).
- R3: A precharge to a bank whose last write was not single-beat, or while `cfg_swr_hold`=0, is accepted only when at least 1 cycle (`cfg_tdp_sel`=0) or 2 cycles (`cfg_tdp_sel`=1) have passed since that bank's last accepted write.
- R4: While `cfg_swr_hold`=1, a precharge to a bank whose last accepted write had `req_single`=1 waits until at least 4 cycles after that write. Clearing `cfg_swr_hold` returns the bank to the R3 spacing.
- R5: Spacing is tracked per bank. A command is never delayed by the history of a different bank.
- R6: A request held on `req_valid` stays pending and is accepted in the first cycle in which its spacing is met. In that cycle `cmd_acc` is 1, `iss_cmd` equals `req_cmd` and `iss_bank` equals `req_bank`. In every other cycle `cmd_acc` is 0 and `iss_cmd` and `iss_bank` are 0 (code 0 is no-operation).
- R7: While reset is asserted nothing is accepted. After reset every spacing counts as already met, so a first command to any bank is accepted in the cycle it is presented.
- R8: The configuration inputs are read every cycle. A change applies to a command that is already pending, starting in the cycle of the change.
- R9: Elapsed-cycle tracking saturates and never wraps. A command presented any number of cycles after the event that governs it is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A command is being requested |
| req_cmd | input | 3 | Requested command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge |
| req_bank | input | BANK_W | Target bank of the request |
| req_single | input | 1 | Write is a single-beat write |
| cfg_trcd_sel | input | 1 | Activate-to-column spacing select |
| cfg_trp_sel | input | 1 | Precharge-to-activate spacing select |
| cfg_tdp_sel | input | 1 | Write-to-precharge spacing select |
| cfg_swr_hold | input | 1 | Enable the longer hold after single-beat writes |
| cmd_acc | output | 1 | Request accepted and issued this cycle |
| iss_cmd | output | 3 | Command driven to the memory, no-op when idle |
| iss_bank | output | BANK_W | Bank driven with the issued command |

## Verification
The bench builds the gate with its defaults: four banks, spacings of 2/3, 2/3 and 1/2 cycles, and a single-write hold of 4. The counters are therefore 3 bits wide and saturate at 4. With only four banks, random traffic keeps returning to the same bank while its counters are still running, so every spacing value is hit often. A directed gap of 256 cycles is a multiple of the counter range, which means a counter that wrapped instead of saturating would read zero at the moment the command is presented.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sd_cmd_e;

  // Two-way spacing choice driven by a single select bit.
  function automatic int pick_gap(logic sel, int lo, int hi);
    return sel ? hi : lo;
  endfunction

  // Spacing between a write and the following precharge.
  function automatic int wr_pre_gap(logic sel, logic hold, logic single,
                                    int lo, int hi, int swr);
    return (hold && single) ? swr : pick_gap(sel, lo, hi);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sgate_sat_ctr.sv
module sgate_sat_ctr #(
  parameter int CNT_W   = 3,
  parameter int MAX_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_GAP);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_top;
  assign at_top = (count >= TOP);

  // Value equals cycles since the last restart, held at TOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= TOP;
    else if (restart) count <= ONE;
    else if (!at_top) count <= count + ONE;
  end

endmodule

// File: rtl/sgate_bank_timer.sv
module sgate_bank_timer #(
  parameter int CNT_W   = 3,
  parameter int MAX_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_act,
  input  logic             ev_pre,
  input  logic             ev_wr,
  input  logic             wr_single,
  output logic [CNT_W-1:0] since_act,
  output logic [CNT_W-1:0] since_pre,
  output logic [CNT_W-1:0] since_wr,
  output logic             wr_was_single
);

  sgate_sat_ctr #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_act (
    .clk(clk), .rst_n(rst_n), .restart(ev_act), .count(since_act));

  sgate_sat_ctr #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ev_pre), .count(since_pre));

  sgate_sat_ctr #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_wr (
    .clk(clk), .rst_n(rst_n), .restart(ev_wr), .count(since_wr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_was_single <= 1'b0;
    else if (ev_wr) wr_was_single <= wr_single;
  end

endmodule

// File: rtl/sgate_rule.sv
module sgate_rule
  import sgate_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int TRCD_LO = 2,
  parameter int TRCD_HI = 3,
  parameter int TRP_LO  = 2,
  parameter int TRP_HI  = 3,
  parameter int TDP_LO  = 1,
  parameter int TDP_HI  = 2,
  parameter int SWR_GAP = 4
) (
  input  logic [2:0]       cmd,
  input  logic [CNT_W-1:0] since_act,
  input  logic [CNT_W-1:0] since_pre,
  input  logic [CNT_W-1:0] since_wr,
  input  logic             wr_was_single,
  input  logic             cfg_trcd_sel,
  input  logic             cfg_trp_sel,
  input  logic             cfg_tdp_sel,
  input  logic             cfg_swr_hold,
  output logic             rcd_met,
  output logic             rp_met,
  output logic             dp_met,
  output logic             gap_ok
);

  logic [CNT_W-1:0] need_rcd, need_rp, need_dp;

  assign need_rcd = CNT_W'(pick_gap(cfg_trcd_sel, TRCD_LO, TRCD_HI));
  assign need_rp  = CNT_W'(pick_gap(cfg_trp_sel, TRP_LO, TRP_HI));
  assign need_dp  = CNT_W'(wr_pre_gap(cfg_tdp_sel, cfg_swr_hold, wr_was_single,
                                      TDP_LO, TDP_HI, SWR_GAP));

  assign rcd_met = (since_act >= need_rcd);
  assign rp_met  = (since_pre >= need_rp);
  assign dp_met  = (since_wr  >= need_dp);

  always_comb begin
    case (sd_cmd_e'(cmd))
      CMD_ACT: gap_ok = rp_met;
      CMD_RD,
      CMD_WR:  gap_ok = rcd_met;
      CMD_PRE: gap_ok = dp_met;
      default: gap_ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sgate_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int TRCD_LO = 2,
  parameter int TRCD_HI = 3,
  parameter int TRP_LO  = 2,
  parameter int TRP_HI  = 3,
  parameter int TDP_LO  = 1,
  parameter int TDP_HI  = 2,
  parameter int SWR_GAP = 4,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_single,
  input  logic              cfg_trcd_sel,
  input  logic              cfg_trp_sel,
  input  logic              cfg_tdp_sel,
  input  logic              cfg_swr_hold,
  output logic              cmd_acc,
  output logic [2:0]        iss_cmd,
  output logic [BANK_W-1:0] iss_bank
);

  localparam int MAX_GAP = max2(max2(max2(TRCD_LO, TRCD_HI), max2(TRP_LO, TRP_HI)),
                                max2(max2(TDP_LO, TDP_HI), SWR_GAP));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic [CNT_W-1:0] act_cnt [NBANK];
  logic [CNT_W-1:0] pre_cnt [NBANK];
  logic [CNT_W-1:0] wr_cnt  [NBANK];
  logic             wr_single_q [NBANK];

  // Named events for the checker.
  logic issue_act, issue_pre, issue_wr;
  logic rcd_met, rp_met, dp_met, gap_ok;

  assign issue_act = cmd_acc && (req_cmd == CMD_ACT);
  assign issue_pre = cmd_acc && (req_cmd == CMD_PRE);
  assign issue_wr  = cmd_acc && (req_cmd == CMD_WR);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BANK_W'(b));
    sgate_bank_timer #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_tmr (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_act        (issue_act && hit),
      .ev_pre        (issue_pre && hit),
      .ev_wr         (issue_wr && hit),
      .wr_single     (req_single),
      .since_act     (act_cnt[b]),
      .since_pre     (pre_cnt[b]),
      .since_wr      (wr_cnt[b]),
      .wr_was_single (wr_single_q[b])
    );
  end

  sgate_rule #(
    .CNT_W(CNT_W), .TRCD_LO(TRCD_LO), .TRCD_HI(TRCD_HI),
    .TRP_LO(TRP_LO), .TRP_HI(TRP_HI), .TDP_LO(TDP_LO), .TDP_HI(TDP_HI),
    .SWR_GAP(SWR_GAP)
  ) u_rule (
    .cmd           (req_cmd),
    .since_act     (act_cnt[req_bank]),
    .since_pre     (pre_cnt[req_bank]),
    .since_wr      (wr_cnt[req_bank]),
    .wr_was_single (wr_single_q[req_bank]),
    .cfg_trcd_sel  (cfg_trcd_sel),
    .cfg_trp_sel   (cfg_trp_sel),
    .cfg_tdp_sel   (cfg_tdp_sel),
    .cfg_swr_hold  (cfg_swr_hold),
    .rcd_met       (rcd_met),
    .rp_met        (rp_met),
    .dp_met        (dp_met),
    .gap_ok        (gap_ok)
  );

  assign cmd_acc  = rst_n && req_valid && gap_ok;
  assign iss_cmd  = cmd_acc ? req_cmd  : CMD_NOP;
  assign iss_bank = cmd_acc ? req_bank : '0;

endmodule

// File: rtl/sgate_checker.sv
module sgate_checker
  import sgate_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int BANK_W  = 2,
  parameter int TRCD_LO = 2,
  parameter int TRCD_HI = 3,
  parameter int TRP_LO  = 2,
  parameter int TRP_HI  = 3,
  parameter int TDP_LO  = 1,
  parameter int TDP_HI  = 2,
  parameter int SWR_GAP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_single,
  input logic              cfg_trcd_sel,
  input logic              cfg_trp_sel,
  input logic              cfg_tdp_sel,
  input logic              cfg_swr_hold,
  input logic              cmd_acc,
  input logic [2:0]        iss_cmd,
  input logic [BANK_W-1:0] iss_bank
);

  // Independent timestamps of the issued stream, per bank.
  int unsigned cyc;
  int unsigned t_act [NBANK];
  int unsigned t_pre [NBANK];
  int unsigned t_wr  [NBANK];
  logic        s_act [NBANK];
  logic        s_pre [NBANK];
  logic        s_wr  [NBANK];
  logic        w_one [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0;
      for (int i = 0; i < NBANK; i++) begin
        t_act[i] <= 0; t_pre[i] <= 0; t_wr[i] <= 0;
        s_act[i] <= 1'b0; s_pre[i] <= 1'b0; s_wr[i] <= 1'b0; w_one[i] <= 1'b0;
      end
    end else begin
      cyc <= cyc + 1;
      if (cmd_acc) begin
        case (iss_cmd)
          CMD_ACT: begin t_act[iss_bank] <= cyc; s_act[iss_bank] <= 1'b1; end
          CMD_PRE: begin t_pre[iss_bank] <= cyc; s_pre[iss_bank] <= 1'b1; end
          CMD_WR:  begin
            t_wr[iss_bank] <= cyc; s_wr[iss_bank] <= 1'b1; w_one[iss_bank] <= req_single;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && (iss_cmd == CMD_RD || iss_cmd == CMD_WR) && s_act[iss_bank])
      |-> (cyc - t_act[iss_bank] >= pick_gap(cfg_trcd_sel, TRCD_LO, TRCD_HI)));

  a_r2_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && iss_cmd == CMD_ACT && s_pre[iss_bank])
      |-> (cyc - t_pre[iss_bank] >= pick_gap(cfg_trp_sel, TRP_LO, TRP_HI)));

  a_r3_wr_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && iss_cmd == CMD_PRE && s_wr[iss_bank])
      |-> (cyc - t_wr[iss_bank] >= pick_gap(cfg_tdp_sel, TDP_LO, TDP_HI)));

  a_r4_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && iss_cmd == CMD_PRE && s_wr[iss_bank] && w_one[iss_bank] && cfg_swr_hold)
      |-> (cyc - t_wr[iss_bank] >= SWR_GAP));

  a_r6_acc_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |-> req_valid);

endmodule

bind sdram_cmd_gate sgate_checker #(
  .NBANK(NBANK), .BANK_W(BANK_W), .TRCD_LO(TRCD_LO), .TRCD_HI(TRCD_HI),
  .TRP_LO(TRP_LO), .TRP_HI(TRP_HI), .TDP_LO(TDP_LO), .TDP_HI(TDP_HI),
  .SWR_GAP(SWR_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
  .cfg_trcd_sel(cfg_trcd_sel), .cfg_trp_sel(cfg_trp_sel),
  .cfg_tdp_sel(cfg_tdp_sel), .cfg_swr_hold(cfg_swr_hold),
  .cmd_acc(cmd_acc), .iss_cmd(iss_cmd), .iss_bank(iss_bank)
);

// File: tb/sim_sdram_cmd_gate.sv
module sim_sdram_cmd_gate;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       req_valid, req_single;
  logic [2:0] req_cmd;
  logic [1:0] req_bank;
  logic       cfg_trcd_sel, cfg_trp_sel, cfg_tdp_sel, cfg_swr_hold;
  logic       cmd_acc;
  logic [2:0] iss_cmd;
  logic [1:0] iss_bank;

  sdram_cmd_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_single(req_single),
    .cfg_trcd_sel(cfg_trcd_sel), .cfg_trp_sel(cfg_trp_sel),
    .cfg_tdp_sel(cfg_tdp_sel), .cfg_swr_hold(cfg_swr_hold),
    .cmd_acc(cmd_acc), .iss_cmd(iss_cmd), .iss_bank(iss_bank)
  );

  int  vecs = 0, bad = 0, t = 0;
  bit  done = 0, last_exp;
  int  la[4], lp[4], lw[4];
  bit  ls[4];

  function automatic int need_for(logic [2:0] c, int b);
    case (c)
      3'd1: return cfg_trp_sel ? 3 : 2;
      3'd2, 3'd3: return cfg_trcd_sel ? 3 : 2;
      3'd4: return (cfg_swr_hold && ls[b]) ? 4 : (cfg_tdp_sel ? 2 : 1);
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_accept(logic [2:0] c, int b);
    int since;
    case (c)
      3'd1: since = t - lp[b];
      3'd2, 3'd3: since = t - la[b];
      3'd4: since = t - lw[b];
      default: since = 1000;
    endcase
    return since >= need_for(c, b);
  endfunction

  function automatic string auto_tag(logic [2:0] c, int b);
    case (c)
      3'd1: return "R2";
      3'd4: return (cfg_swr_hold && ls[b]) ? "R4" : "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic fail_line(string tag, string what, int act, int exp);
    bad++;
    $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", tag, what, act, exp, t);
  endtask

  task automatic chk_eq(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) fail_line(tag, what, act, exp);
  endtask

  // Called just after a negedge with inputs set; checks, updates model, moves to next negedge.
  task automatic tick(string tag);
    bit e;
    string tg;
    int b;
    #1;
    b  = int'(req_bank);
    e  = req_valid && exp_accept(req_cmd, b);
    tg = (tag == "") ? auto_tag(req_cmd, b) : tag;
    vecs++;
    if (cmd_acc !== e) fail_line(tg, "cmd_acc", int'(cmd_acc), int'(e));
    if (iss_cmd !== (e ? req_cmd : 3'd0)) fail_line("R6", "iss_cmd", int'(iss_cmd), e ? int'(req_cmd) : 0);
    if (iss_bank !== (e ? req_bank : 2'd0)) fail_line("R6", "iss_bank", int'(iss_bank), e ? b : 0);
    if (e) begin
      case (req_cmd)
        3'd1: la[b] = t;
        3'd3: begin lw[b] = t; ls[b] = req_single; end
        3'd4: lp[b] = t;
        default: ;
      endcase
    end
    last_exp = e;
    t++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 0; req_cmd = 0; req_bank = 0; req_single = 0;
    for (int i = 0; i < n; i++) tick("R6");
  endtask

  task automatic issue(logic [2:0] c, logic [1:0] b, bit s, string tag, output int waits);
    waits = 0;
    req_valid = 1; req_cmd = c; req_bank = b; req_single = s;
    forever begin
      tick(tag);
      if (last_exp) break;
      waits++;
      if (waits > 20) begin fail_line(tag, "hang", waits, 0); break; end
    end
    req_valid = 0; req_cmd = 0;
  endtask

  initial begin
    #(200000 * 10);
    fail_line("R6", "watchdog", 1, 0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    end
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin la[i] = -100; lp[i] = -100; lw[i] = -100; ls[i] = 0; end
    rst_n = 0; req_valid = 1; req_cmd = 3'd1; req_bank = 0; req_single = 0;
    cfg_trcd_sel = 0; cfg_trp_sel = 0; cfg_tdp_sel = 0; cfg_swr_hold = 1;
    // R7: no accept while in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk_eq("R7", "cmd_acc in reset", int'(cmd_acc), 0);
      chk_eq("R7", "iss_cmd in reset", int'(iss_cmd), 0);
    end
    @(negedge clk);
    rst_n = 1;
    // R7: first activate passes at once
    issue(3'd1, 2'd0, 0, "R7", w); chk_eq("R7", "first ACT wait", w, 0);
    issue(3'd4, 2'd1, 0, "R7", w); chk_eq("R7", "first PRE wait", w, 0);

    // R1
    cfg_trcd_sel = 1; idle(8);
    issue(3'd1, 2'd1, 0, "R1", w); issue(3'd2, 2'd1, 0, "R1", w);
    chk_eq("R1", "RD after ACT, sel1", w, 2);
    cfg_trcd_sel = 0; idle(8);
    issue(3'd1, 2'd2, 0, "R1", w); issue(3'd3, 2'd2, 0, "R1", w);
    chk_eq("R1", "WR after ACT, sel0", w, 1);

    // R5
    idle(8);
    issue(3'd1, 2'd0, 0, "R5", w);
    issue(3'd1, 2'd3, 0, "R5", w); chk_eq("R5", "ACT other bank", w, 0);
    issue(3'd2, 2'd3, 0, "R5", w); chk_eq("R5", "RD uses own bank", w, 1);

    // R3
    cfg_swr_hold = 1; cfg_tdp_sel = 0; idle(8);
    issue(3'd3, 2'd1, 0, "R3", w); issue(3'd4, 2'd1, 0, "R3", w);
    chk_eq("R3", "PRE after WR, sel0", w, 0);
    cfg_tdp_sel = 1; idle(8);
    issue(3'd3, 2'd1, 0, "R3", w); issue(3'd4, 2'd1, 0, "R3", w);
    chk_eq("R3", "PRE after WR, sel1", w, 1);

    // R4
    cfg_tdp_sel = 0; cfg_swr_hold = 1; idle(8);
    issue(3'd3, 2'd2, 1, "R4", w); issue(3'd4, 2'd2, 0, "R4", w);
    chk_eq("R4", "PRE after single WR, hold", w, 3);
    cfg_swr_hold = 0; idle(8);
    issue(3'd3, 2'd2, 1, "R4", w); issue(3'd4, 2'd2, 0, "R4", w);
    chk_eq("R4", "PRE after single WR, hold cleared", w, 0);

    // R2
    cfg_trp_sel = 1; idle(8);
    issue(3'd4, 2'd3, 0, "R2", w); issue(3'd1, 2'd3, 0, "R2", w);
    chk_eq("R2", "ACT after PRE, sel1", w, 2);
    cfg_trp_sel = 0; idle(8);
    issue(3'd4, 2'd3, 0, "R2", w); issue(3'd1, 2'd3, 0, "R2", w);
    chk_eq("R2", "ACT after PRE, sel0", w, 1);

    // R8: select drops while a read is pending
    cfg_trcd_sel = 1; idle(8);
    issue(3'd1, 2'd1, 0, "R8", w);
    req_valid = 1; req_cmd = 3'd2; req_bank = 2'd1;
    tick("R8"); chk_eq("R8", "pending at distance 1", int'(last_exp), 0);
    cfg_trcd_sel = 0;
    tick("R8"); chk_eq("R8", "accept after select change", int'(last_exp), 1);
    req_valid = 0;

    // R9: gaps of 256 cycles, a multiple of the counter range
    cfg_trcd_sel = 1; cfg_trp_sel = 1; idle(8);
    issue(3'd1, 2'd0, 0, "R9", w); idle(255);
    issue(3'd2, 2'd0, 0, "R9", w); chk_eq("R9", "RD after long idle", w, 0);
    issue(3'd4, 2'd2, 0, "R9", w); idle(255);
    issue(3'd1, 2'd2, 0, "R9", w); chk_eq("R9", "ACT after long idle", w, 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] c;
      if ($urandom % 8 == 0) begin
        cfg_trcd_sel = $urandom % 2; cfg_trp_sel = $urandom % 2;
        cfg_tdp_sel = $urandom % 2;  cfg_swr_hold = $urandom % 2;
      end
      c = 3'(1 + $urandom % 4);
      issue(c, 2'($urandom % 4), 1'($urandom % 2), "", w);
      if ($urandom % 4 == 0) idle(1);
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    end
    $finish;
  end

endmodule